// File: doc/BRIEF.md
# Standby IO Hold Status Register

This block keeps one status bit for each pin of a 16-pin IO port. Each bit records whether the output level of that pin is being frozen across a standby period. The power sequencer sends a one-cycle standby-entry pulse. On that pulse, every pin whose hold enable is asserted in the same cycle gets its status bit set. Software acknowledges a bit by writing zero to it after wake-up. Writing one leaves the bit as it is.

Accesses arrive on a simple single-cycle register bus. Each access carries an address, a read/write flag, write data, a secure attribute and a privileged attribute. Every pin has its own security input. A secured bit is invisible to non-secure accesses: it reads as zero and writes to it are ignored. Two privilege controls can further restrict unprivileged accesses. One applies to secure bits and the other to non-secure bits. A blocked access has the same silent effect as a security block. No access ever produces an error or an interrupt.

The hold enables, the per-pin security inputs and the privilege controls come from other registers and enter the block as inputs. The live status vector is also driven out to the power logic.

Top module: `iohold_stat_reg`

## Requirements
- R1: After reset, all 16 status bits and the read data output are 0.
- R2: In a cycle where `standby_pulse` is 1, every bit y with `hold_en[y]`=1 in that same cycle is 1 afterwards. Bits with `hold_en[y]`=0 keep their value.
- R3: A permitted write to address `REG_ADDR` (default 0) clears bit y when `bus_wdata[y]`=0. Writing 1 to a bit leaves it unchanged, and no bit ever goes from 0 to 1 without a standby pulse.
- R4: If a standby set and a software clear hit the same bit in the same cycle, the bit ends up 1.
- R5: When `pin_sec[y]`=1, a non-secure access (`bus_secure`=0) reads 0 at bit y, and a non-secure write leaves bit y unchanged.
- R6: A secure access may read and clear both secure and non-secure bits, subject to R7 and R8.
- R7: With `sec_priv_only`=1, an unprivileged access (`bus_priv`=0) reads 0 at every secure bit, and its writes leave those bits unchanged.
- R8: With `ns_priv_only`=1, an unprivileged access reads 0 at every non-secure bit, and its writes leave those bits unchanged.
- R9: Read data appears on `bus_rdata` in the cycle after the read request. It shows the status as it was before any update in the request cycle, and it holds until the next read.
- R10: A read from any address other than `REG_ADDR` returns 0. A write to such an address changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Register address |
| bus_wdata | input | N (16) | Write data; a 0 clears the bit |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | N (16) | Filtered read data, registered |
| pin_sec | input | N (16) | Per-pin security marking |
| sec_priv_only | input | 1 | Secure bits need privileged access |
| ns_priv_only | input | 1 | Non-secure bits need privileged access |
| hold_en | input | N (16) | Per-pin hold enable |
| standby_pulse | input | 1 | One-cycle standby-entry event |
| hold_status | output | N (16) | Live status bits |

## Verification
On every cycle, the assertions check four things. Enabled bits are set after a standby pulse. No bit rises without one. Non-secure writes leave secured bits alone, and non-secure or unprivileged reads mask the bits they may not see. Unmapped reads return zero, and read data holds between reads. Other behaviour can only be shown by the bench's directed scenarios against its reference model: the set-over-clear collision, the exact bits a permitted write clears, the pre-update value returned by a read that coincides with a pulse, and the interplay of the two privilege controls with secure accesses.

// File: rtl/iohold_pkg.sv
package iohold_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // Grant rule for one bit: security first, then the privilege control
  // belonging to that bit's security class.
  function automatic logic bit_grant(
    input logic bit_is_sec,
    input logic acc_sec,
    input logic acc_priv,
    input logic sec_po,
    input logic ns_po
  );
    logic g;
    if (bit_is_sec) g = acc_sec & (~sec_po | acc_priv);
    else            g = ~ns_po | acc_priv;
    return g;
  endfunction

endpackage

// File: rtl/iohold_rst_sync.sv
module iohold_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/iohold_acc_decode.sv
module iohold_acc_decode
  import iohold_pkg::*;
#(
  parameter int AW       = 4,
  parameter int REG_ADDR = 0
) (
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  output acc_kind_e     acc_kind,
  output logic          addr_hit
);
  localparam logic [AW-1:0] HIT_ADDR = AW'(REG_ADDR);

  always_comb begin
    addr_hit = (bus_addr == HIT_ADDR);
    acc_kind = ACC_IDLE;
    if (bus_req) acc_kind = bus_we ? ACC_WRITE : ACC_READ;
  end
endmodule

// File: rtl/iohold_perm_mask.sv
module iohold_perm_mask
  import iohold_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] pin_sec,
  input  logic         acc_sec,
  input  logic         acc_priv,
  input  logic         sec_po,
  input  logic         ns_po,
  output logic [N-1:0] allow
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign allow[g] = bit_grant(pin_sec[g], acc_sec, acc_priv, sec_po, ns_po);
  end
endmodule

// File: rtl/iohold_stat_bit.sv
module iohold_stat_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic q
);
  logic q_nxt;
  logic q_en;

  // Set dominates a simultaneous clear.
  always_comb begin
    q_en  = set_ev | clr_ev;
    q_nxt = set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/iohold_rd_port.sv
module iohold_rd_port #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  logic         addr_hit,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] allow,
  output logic [N-1:0] rdata
);
  logic [N-1:0] rdata_nxt;

  always_comb begin
    rdata_nxt = addr_hit ? (stat & allow) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rdata_nxt;
  end
endmodule

// File: rtl/iohold_stat_reg.sv
module iohold_stat_reg
  import iohold_pkg::*;
#(
  parameter int N        = 16,
  parameter int AW       = 4,
  parameter int REG_ADDR = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  input  logic          bus_secure,
  input  logic          bus_priv,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  pin_sec,
  input  logic          sec_priv_only,
  input  logic          ns_priv_only,
  input  logic [N-1:0]  hold_en,
  input  logic          standby_pulse,
  output logic [N-1:0]  hold_status
);
  logic         rst_n_int;
  acc_kind_e    acc_kind;
  logic         addr_hit;
  logic         wr_take;
  logic         rd_take;
  logic [N-1:0] allow;
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;

  iohold_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  iohold_acc_decode #(.AW(AW), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .acc_kind (acc_kind),
    .addr_hit (addr_hit)
  );

  iohold_perm_mask #(.N(N)) u_perm (
    .pin_sec  (pin_sec),
    .acc_sec  (bus_secure),
    .acc_priv (bus_priv),
    .sec_po   (sec_priv_only),
    .ns_po    (ns_priv_only),
    .allow    (allow)
  );

  always_comb begin
    wr_take = (acc_kind == ACC_WRITE) && addr_hit;
    rd_take = (acc_kind == ACC_READ);
  end

  for (genvar g = 0; g < N; g++) begin : g_cell
    assign set_vec[g] = standby_pulse & hold_en[g];
    assign clr_vec[g] = wr_take & allow[g] & ~bus_wdata[g];

    iohold_stat_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .set_ev (set_vec[g]),
      .clr_ev (clr_vec[g]),
      .q      (hold_status[g])
    );
  end

  iohold_rd_port #(.N(N)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rd_en    (rd_take),
    .addr_hit (addr_hit),
    .stat     (hold_status),
    .allow    (allow),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/iohold_stat_chk.sv
module iohold_stat_chk #(
  parameter int N        = 16,
  parameter int AW       = 4,
  parameter int REG_ADDR = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_secure,
  input logic          bus_priv,
  input logic [N-1:0]  bus_rdata,
  input logic [N-1:0]  pin_sec,
  input logic          ns_priv_only,
  input logic [N-1:0]  hold_en,
  input logic          standby_pulse,
  input logic [N-1:0]  hold_status
);
  // R2
  set_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_pulse |=> ((hold_status & $past(hold_en)) == $past(hold_en)));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_pulse |=> ((hold_status & ~$past(hold_status)) == '0));

  // R5
  ns_write_keeps_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_secure) |=>
      (($past(hold_status & pin_sec) & ~hold_status) == '0));

  // R5
  ns_read_masks_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && !bus_secure) |=> ((bus_rdata & $past(pin_sec)) == '0));

  // R8
  ns_unpriv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && !bus_priv && ns_priv_only) |=>
      ((bus_rdata & ~$past(pin_sec)) == '0));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && (bus_addr != AW'(REG_ADDR))) |=> (bus_rdata == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> $stable(bus_rdata));
endmodule

bind iohold_stat_reg iohold_stat_chk #(.N(N), .AW(AW), .REG_ADDR(REG_ADDR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req       (bus_req),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_secure    (bus_secure),
  .bus_priv      (bus_priv),
  .bus_rdata     (bus_rdata),
  .pin_sec       (pin_sec),
  .ns_priv_only  (ns_priv_only),
  .hold_en       (hold_en),
  .standby_pulse (standby_pulse),
  .hold_status   (hold_status)
);

// File: tb/tb_iohold_stat_reg.sv
`timescale 1ns/1ps
module tb_iohold_stat_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_secure = 1'b0, bus_priv = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, pin_sec = '0, hold_en = '0;
  logic        sec_priv_only = 1'b0, ns_priv_only = 1'b0, standby_pulse = 1'b0;
  logic [15:0] bus_rdata, hold_status;

  int nchk = 0, nfail = 0;
  string cur_req = "R1";
  logic [15:0] m_stat, m_rdata;

  always #2 clk = ~clk;

  iohold_stat_reg dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .pin_sec(pin_sec),
    .sec_priv_only(sec_priv_only), .ns_priv_only(ns_priv_only),
    .hold_en(hold_en), .standby_pulse(standby_pulse), .hold_status(hold_status)
  );

  // Behavioural reference model built from the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat  <= '0;
      m_rdata <= '0;
    end else begin
      logic [15:0] ns, rd;
      ns = m_stat;
      rd = '0;
      for (int y = 0; y < 16; y++) begin
        bit ok;
        if (pin_sec[y]) ok = bus_secure && (!sec_priv_only || bus_priv);
        else            ok = !ns_priv_only || bus_priv;
        if (bus_req && !bus_we && bus_addr == 4'd0 && ok) rd[y] = m_stat[y];
        if (bus_req && bus_we && bus_addr == 4'd0 && ok && !bus_wdata[y]) ns[y] = 1'b0;
        if (standby_pulse && hold_en[y]) ns[y] = 1'b1;
      end
      m_stat <= ns;
      if (bus_req && !bus_we) m_rdata <= rd;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check({cur_req, " status"}, hold_status, m_stat);
      check({cur_req, " rdata"}, bus_rdata, m_rdata);
    end
  end

  task automatic bus_op(input logic req, input logic we, input logic [3:0] addr,
                        input logic [15:0] wd, input logic sec, input logic priv,
                        input logic pulse, input logic [15:0] en);
    @(negedge clk);
    bus_req = req; bus_we = we; bus_addr = addr; bus_wdata = wd;
    bus_secure = sec; bus_priv = priv; standby_pulse = pulse; hold_en = en;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; standby_pulse = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check("R1", hold_status, 16'h0000);
    check("R1", bus_rdata, 16'h0000);

    cur_req = "R2";
    bus_op(0, 0, 0, 16'h0, 1, 1, 1, 16'hA5C3);
    check("R2", hold_status, 16'hA5C3);
    bus_op(0, 0, 0, 16'h0, 1, 1, 0, 16'hFFFF);
    check("R2", hold_status, 16'hA5C3);

    cur_req = "R9";
    bus_op(1, 0, 0, 16'h0, 1, 1, 0, 16'h0000);
    check("R9", bus_rdata, 16'hA5C3);

    cur_req = "R3";
    bus_op(1, 1, 0, 16'hFF0F, 1, 1, 0, 16'h0000);
    check("R3", hold_status, 16'hA503);

    cur_req = "R4";
    bus_op(1, 1, 0, 16'hFFEF, 1, 1, 1, 16'h0010);
    check("R4", hold_status, 16'hA513);

    cur_req = "R5";
    pin_sec = 16'hFF00;
    bus_op(1, 0, 0, 16'h0, 0, 1, 0, 16'h0000);
    check("R5", bus_rdata, 16'h0013);
    bus_op(1, 1, 0, 16'h0000, 0, 1, 0, 16'h0000);
    check("R5", hold_status, 16'hA500);

    cur_req = "R6";
    bus_op(0, 0, 0, 16'h0, 1, 1, 1, 16'h00FF);
    check("R6", hold_status, 16'hA5FF);
    bus_op(1, 1, 0, 16'h0FF0, 1, 1, 0, 16'h0000);
    check("R6", hold_status, 16'h05F0);

    cur_req = "R7";
    sec_priv_only = 1'b1;
    bus_op(1, 0, 0, 16'h0, 1, 0, 0, 16'h0000);
    check("R7", bus_rdata, 16'h00F0);
    bus_op(1, 1, 0, 16'h0000, 1, 0, 0, 16'h0000);
    check("R7", hold_status, 16'h0500);

    cur_req = "R8";
    sec_priv_only = 1'b0;
    ns_priv_only  = 1'b1;
    bus_op(0, 0, 0, 16'h0, 1, 1, 1, 16'hFFFF);
    bus_op(1, 0, 0, 16'h0, 0, 0, 0, 16'h0000);
    check("R8", bus_rdata, 16'h0000);
    bus_op(1, 0, 0, 16'h0, 1, 0, 0, 16'h0000);
    check("R8", bus_rdata, 16'hFF00);
    bus_op(1, 1, 0, 16'h0000, 1, 0, 0, 16'h0000);
    check("R8", hold_status, 16'h00FF);

    cur_req = "R10";
    bus_op(1, 0, 4'h3, 16'h0, 1, 1, 0, 16'h0000);
    check("R10", bus_rdata, 16'h0000);
    bus_op(1, 1, 4'h3, 16'h0000, 1, 1, 0, 16'h0000);
    check("R10", hold_status, 16'h00FF);

    cur_req = "R9";
    bus_op(1, 0, 0, 16'h0, 1, 1, 0, 16'h0000);
    repeat (2) @(negedge clk);
    check("R9", bus_rdata, 16'h00FF);
    bus_op(1, 0, 0, 16'h0, 1, 1, 1, 16'hFF00);
    check("R9", bus_rdata, 16'h00FF);
    check("R9", hold_status, 16'hFFFF);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule